// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a master for the two-wire station management bus that configures Ethernet PHYs. It forms clause-22 frames. Software loads one 32-bit frame word that holds the start pattern, opcode, PHY address, register address, turnaround and data. That write starts the frame. The block can first send a run of ones as a preamble, then shifts the word out most significant bit first. The data line is driven while the management clock is low and is stable while the clock is high. For a read frame the block releases the data line at the turnaround field and collects sixteen bits from the PHY.

The frame word is also the shift register. While a frame runs, its readback value is scrambled. Each bit that leaves the top is fed back in at the bottom, so when the frame ends the word again holds what was written. After a read, the low sixteen bits hold the value the PHY returned. A sticky completion flag, gated by an enable, drives the interrupt line. A small control word sets the management clock rate and can drop the preamble. The divider count inside the clock generator can be read back for production test.

Register map, word addressed by `reg_addr`:
- 0: frame word.
- 1: control. Bits 6:1 are the speed S. Bit 7 set means no preamble. Bits 21:16 are the read-only divider count.
- 2: status. Bit 0 is the done flag.
- 3: interrupt enable. Bit 0.

Top module: `mdio_master`

## Requirements
- R1: After reset, the frame word, control word, status flag and enable all read 0. `mdc` is low and `mdio_oe` is low.
- R2: While a frame is active, `mdc` stays low for S system clocks and then high for S system clocks, so its period is 2×S. Control bits 21:16 show a divider count that steps 0,1,…,S-1 and wraps. When no frame is active, `mdc` stays low.
- R3: With S = 0, a write to the frame word stores the value but starts no frame. `mdc` does not toggle and no completion is flagged.
- R4: When control bit 7 is 0, each frame begins with 32 bit times of `mdio_o`=1 with `mdio_oe`=1. When bit 7 is 1, the frame word follows at once.
- R5: The frame word goes out MSB first, one bit per `mdc` period. Each bit is valid at the rising edge of `mdc`. A write frame (opcode bits 29:28 = 01) drives `mdio_oe` high for every bit time.
- R6: For a read frame (bits 29:28 = 10), `mdio_oe` is low from the turnaround field (bits 17:16) to the end of the frame. `mdio_i` is sampled at the `mdc` rising edges of the sixteen data bit times, MSB first.
- R7: At completion the frame word reads back as the written value. For a read frame, bits 15:0 are replaced by the received data.
- R8: The status flag is set exactly 2×S×(64, or 32 with no preamble) system clocks after the clock edge that accepts the frame write.
- R9: The status flag stays set until a write to address 2 with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R10: `irq` is high exactly when the status flag and enable bit 0 (address 3) are both set.
- R11: A write to the frame word during a frame is not blocked or queued. It replaces the bits not yet sent, the frame length is unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps S from 1 to 3, with the preamble on and off, over read and write frames. An off-by-one in the half-period divider would show up as a wrong frame length or a wrong count of clock edges. If the rotation did not feed the top bit back in, or took the captured bit at the wrong step, the readback word would come out shifted or with its data field in the wrong place. A read that released the line late, or sampled a bit early, would collide with the PHY or return a shifted value. A rewrite issued right after a frame starts must change the bits on the wire without starting a second frame. With S = 0, a design that still started a frame would hang with its divider running forever.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int SPD_W = 6,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);

  localparam int CW = $clog2(PRE_BITS + 32);
  localparam logic [CW-1:0] LAST = CW'(PRE_BITS + 31);
  localparam logic [CW-1:0] FBASE = CW'(PRE_BITS);

  logic [31:0]      frame_q;
  logic [SPD_W-1:0] spd_q, div_q;
  logic [CW-1:0]    bit_q;
  logic             nopre_q, busy_q, mdc_q, rd_q, smp_q, sts_q, ien_q;

  wire             wr_frame = reg_wr && reg_addr == 2'd0;
  wire             start    = wr_frame && !busy_q && spd_q != '0;
  wire             tick     = busy_q && div_q == spd_q - 1'b1;
  wire             rise     = tick && !mdc_q;
  wire             fall     = tick && mdc_q;
  wire             in_frame = bit_q >= FBASE;
  wire [CW-1:0]    fidx     = bit_q - FBASE;
  wire             done     = fall && bit_q == LAST;
  wire             in_bit   = (rd_q && fidx >= CW'(16)) ? smp_q : frame_q[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (wr_frame) begin
      frame_q <= reg_wdata;
    end else if (fall && in_frame) begin
      frame_q <= {frame_q[30:0], in_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q   <= '0;
      nopre_q <= 1'b0;
      ien_q   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd1) begin
        spd_q   <= reg_wdata[SPD_W:1];
        nopre_q <= reg_wdata[7];
      end
      if (reg_addr == 2'd3) ien_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      rd_q   <= 1'b0;
      smp_q  <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      mdc_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= nopre_q ? FBASE : '0;
      rd_q   <= reg_wdata[29:28] == 2'b10;
    end else if (busy_q) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (rise) begin
        mdc_q <= 1'b1;
        smp_q <= mdio_i;
      end
      if (fall) begin
        mdc_q <= 1'b0;
        if (done) busy_q <= 1'b0;
        else      bit_q  <= bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    sts_q <= 1'b0;
    else if (done)                                 sts_q <= 1'b1;
    else if (reg_wr && reg_addr == 2'd2 && reg_wdata[0]) sts_q <= 1'b0;
  end

  assign mdc     = mdc_q;
  assign mdio_oe = busy_q && !(rd_q && in_frame && fidx >= CW'(14));
  assign mdio_o  = busy_q && (!in_frame || frame_q[31]);
  assign irq     = sts_q && ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata = frame_q;
      2'd1: begin
        reg_rdata[SPD_W:1]       = spd_q;
        reg_rdata[7]             = nopre_q;
        reg_rdata[16+SPD_W-1:16] = div_q;
      end
      2'd2: reg_rdata[0] = sts_q;
      default: reg_rdata[0] = ien_q;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc && !mdio_oe);  // R2
  AST_MDC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && !$stable(mdc) |-> $past(div_q) == spd_q - 1'b1);  // R2
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frame && !busy_q && spd_q == '0 |=> !busy_q);  // R3
  AST_PRE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !in_frame |-> mdio_o && mdio_oe);  // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !rd_q |-> mdio_oe);  // R5
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> sts_q);  // R8

endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic clk = 0, rst_n = 0, reg_wr = 0, mdio_i = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, irq;
  int checks = 0, errors = 0;
  int nrise = 0, nfall = 0, pre_len = 0;
  logic [15:0] phy_val = 0;
  logic cap_o [64];
  logic cap_oe [64];

  mdio_master i_mdio_master (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq));

  always #10 clk = ~clk;

  always @(posedge mdc) if (nrise < 64) begin
    cap_o[nrise] = mdio_o; cap_oe[nrise] = mdio_oe; nrise = nrise + 1;
  end
  always @(negedge mdc) begin
    int fi;
    nfall = nfall + 1;
    fi = nfall - pre_len;
    mdio_i = (fi >= 16 && fi <= 31) ? phy_val[31 - fi] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0h expected %0h", req, act, exp); end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    while (cnt < 2000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic run_frame(input int s, input bit nopre, input bit rd,
                           input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input logic [15:0] rv);
    logic [31:0] w, r, exp;
    int n, cnt, bad_i, fi;
    bit eo, eoe;
    bus_wr(1, (32'(nopre) << 7) | (32'(s) << 1));
    w = {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
    pre_len = nopre ? 0 : 32; n = pre_len + 32;
    nfall = 0; nrise = 0; phy_val = rv;
    bus_wr(0, w);
    wait_done(cnt);
    chk(cnt == 2*s*n, "R8 frame length", cnt, 2*s*n);
    chk(nrise == n, "R2 mdc rising edges", nrise, n);
    bad_i = -1;
    for (int i = 0; i < n; i++) begin
      fi = i - pre_len;
      eo = (fi < 0) ? 1'b1 : w[31 - fi];
      eoe = !(rd && fi >= 14);
      if (cap_oe[i] !== eoe || (eoe && cap_o[i] !== eo)) if (bad_i < 0) bad_i = i;
    end
    chk(bad_i < 0, nopre ? "R5 R6 bit stream" : "R4 R5 R6 bit stream", bad_i, -1);
    bus_rd(0, r);
    exp = rd ? {w[31:16], rv} : w;
    chk(r == exp, "R7 frame word restored", r, exp);
    bus_wr(2, 1);
    @(negedge clk);
    chk(irq == 0, "R9 clear", irq, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++; $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, wa, wb;
    int cnt, prev, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_rd(2'(a), r);
      chk(r == 0, "R1 reset register", r, 0);
    end
    chk(mdc == 0 && mdio_oe == 0, "R1 reset pins", {mdc, mdio_oe}, 0);

    bus_wr(3, 1);
    // R3 speed zero
    nrise = 0; wa = 32'h5A5A_1234;
    bus_wr(0, wa);
    repeat (100) @(negedge clk);
    chk(nrise == 0 && irq == 0, "R3 no frame at speed 0", {nrise, irq}, 0);
    bus_rd(0, r);
    chk(r == wa, "R3 value stored", r, wa);

    // R2 R4 R5 R6 R7 R8 sweep
    for (int s = 1; s <= 3; s++)
      for (int np = 0; np < 2; np++)
        for (int rd = 0; rd < 2; rd++) begin
          run_frame(s, np[0], rd[0], 5'(3 + s), 5'(17 - s), 16'hC3A5 ^ 16'(s * 257), 16'h9E61 + 16'(s));
          run_frame(s, np[0], rd[0], 5'h1F, 5'h00, 16'h0001, 16'h8000);
        end

    // R2 divider count readback, S=3
    bus_wr(1, 3 << 1);
    pre_len = 32; nfall = 0; nrise = 0;
    bus_wr(0, 32'h5003_0000);
    bus_rd(1, r); prev = int'(r[21:16]); bad = 0;
    for (int k = 0; k < 8; k++) begin
      bus_rd(1, r);
      if (int'(r[21:16]) != (prev + 1) % 3) bad++;
      prev = int'(r[21:16]);
    end
    chk(bad == 0, "R2 divider count steps", bad, 0);
    wait_done(cnt);

    // R9 R10 sticky flag and gating
    bus_wr(2, 0);
    bus_rd(2, r);
    chk(r[0] == 1, "R9 write 0 keeps flag", r[0], 1);
    bus_wr(3, 0);
    @(negedge clk);
    chk(irq == 0, "R10 irq masked", irq, 0);
    bus_wr(3, 1);
    @(negedge clk);
    chk(irq == 1, "R10 irq unmasked", irq, 1);
    bus_wr(2, 1);
    bus_rd(2, r);
    chk(r[0] == 0, "R9 write 1 clears", r[0], 0);

    // R11 rewrite right after start, S=2, no preamble
    bus_wr(1, (1 << 7) | (2 << 1));
    pre_len = 0; nfall = 0; nrise = 0;
    wa = {2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h1111};
    wb = {2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'hEDCB};
    bus_wr(0, wa);
    bus_wr(0, wb);
    wait_done(cnt);
    chk(cnt == 2*2*32 - 1, "R11 length unchanged", cnt, 2*2*32 - 1);
    bad = 0;
    for (int i = 0; i < 32; i++) if (cap_o[i] !== wb[31 - i]) bad++;
    chk(bad == 0, "R11 new bits sent", bad, 0);
    bus_rd(0, r);
    chk(r == wb, "R11 final word", r, wb);
    repeat (200) @(negedge clk);
    chk(nrise == 32, "R11 no second frame", nrise, 32);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule